// File: doc/BRIEF.md
# Debug Power and Reset Handshake Controller

This block is the power, clock and reset responder that sits across from a debug port. A debugger requests power for two domains, the debug domain and the system domain, through two independent request/acknowledge pairs. Each pair follows a strict four-phase protocol: request rises, acknowledge rises once the domain has power and clock, request falls, and acknowledge falls once the domain is off again. The restore and shut-down times are parameters counted in clock cycles. Each domain has an enable output that stands in for its power switch and clock gate.

A third pair serves a debug-reset request. The block drives three active-low resets: one for the debug-port bus, one for the debug APB bus and one for the trace bus. It holds them for a minimum number of cycles and then acknowledges. The block's own request and acknowledge logic is not inside that reset, so the acknowledge stays meaningful while the reset is applied. A parameter removes debug-reset support. The acknowledge is then held low for good, so a polling debugger times out and concludes the feature is absent. The block also gates debug-bus access requests, which pass only while the debug domain is acknowledged as powered.

All request inputs are asynchronous and pass through synchronizers of `SYNC_STAGES` flops. With the default of two stages, an output reacts three clock edges after a request edge.

Top module: `dbgpwr_ctl`

## Requirements
- R1: After reset, all three acknowledges and both domain enables are low, and all three reset outputs are high (released).
- R2: When the debug power request rises, `dbg_dom_en` rises 3 cycles later. `dbg_pwr_ack` rises DBG_UP_CYC cycles after that (11 at defaults), while `dbg_dom_en` is high.
- R3: When the system power request rises, `sys_dom_en` rises 3 cycles later and `sys_pwr_ack` rises SYS_UP_CYC cycles after that (19 at defaults).
- R4: Each domain's request affects only its own enable and acknowledge.
- R5: When a power request falls, that domain's enable falls 3 cycles later. Its acknowledge stays high until the shut-down time has elapsed: 3+DBG_DOWN_CYC cycles (7) for the debug domain and 3+SYS_DOWN_CYC cycles (9) for the system domain.
- R6: If a power request is withdrawn before its acknowledge rises, the power-up still completes. The acknowledge rises, then the domain shuts down, and the acknowledge returns low with the enable low.
- R7: When the debug-reset request rises, all three reset outputs go low 3 cycles later. The reset acknowledge rises 3+RST_HOLD_CYC cycles (7) after the request, with all resets still low.
- R8: When the debug-reset request falls, the reset acknowledge falls and all three resets return high 3 cycles later.
- R9: A debug reset does not disturb the power handshakes. A high `dbg_pwr_ack` stays high throughout a debug reset.
- R10: With RST_EN=0, the reset acknowledge stays low and all resets stay high whatever the reset request does.
- R11: Each bit of `dbg_access_out` equals the matching bit of `dbg_access_in` while `dbg_pwr_ack` is high, and is 0 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| dbg_pwr_req | input | 1 | Debug-domain power request (asynchronous) |
| sys_pwr_req | input | 1 | System-domain power request (asynchronous) |
| dbg_rst_req | input | 1 | Debug-reset request (asynchronous) |
| dbg_pwr_ack | output | 1 | Debug-domain power acknowledge |
| sys_pwr_ack | output | 1 | System-domain power acknowledge |
| dbg_rst_ack | output | 1 | Debug-reset acknowledge |
| dbg_dom_en | output | 1 | Debug-domain power and clock enable |
| sys_dom_en | output | 1 | System-domain power and clock enable |
| dap_bus_rst_n | output | 1 | Active-low reset of the debug-port bus |
| dbg_apb_rst_n | output | 1 | Active-low reset of the debug APB bus |
| trace_rst_n | output | 1 | Active-low reset of the trace bus |
| dbg_access_in | input | ACC_W | Debug-bus access requests to be gated |
| dbg_access_out | output | ACC_W | Gated debug-bus access requests |

## Verification
The hardest case to reach is a request withdrawn partway through a power-up. The controller must finish restoring power, raise the acknowledge, and only then start shutting down. The stimulus raises the debug power request and drops it two cycles later, well inside the restore window. The bench then waits for the acknowledge to rise and fall, and checks that the enable ends low. The reset-absent variant is a second instance with RST_EN=0 that shares the same inputs, so every debug-reset scenario also exercises it.

// File: rtl/dbgpwr_pkg.sv
package dbgpwr_pkg;
   typedef enum logic [1:0] {
      DOM_OFF  = 2'd0,
      DOM_UP   = 2'd1,
      DOM_ON   = 2'd2,
      DOM_DOWN = 2'd3
   } dom_state_e;

   typedef enum logic [1:0] {
      RST_IDLE = 2'd0,
      RST_HOLD = 2'd1,
      RST_ACKD = 2'd2
   } rst_state_e;
endpackage

// File: rtl/dbgpwr_sync.sv
module dbgpwr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dbgpwr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-2:0], d_i};
   end

   assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/dbgpwr_domain.sv
module dbgpwr_domain
   import dbgpwr_pkg::*;
#(
   parameter int UP_CYC   = 8,
   parameter int DOWN_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic en_o,
   output logic ack_o
);
   localparam int MAXC = (UP_CYC > DOWN_CYC) ? UP_CYC : DOWN_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   if (UP_CYC < 1 || DOWN_CYC < 1) begin : g_bad_cyc
      $error("dbgpwr_domain: cycle counts must be at least 1");
   end

   dom_state_e state;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= DOM_OFF;
         cnt   <= '0;
      end else begin
         case (state)
            DOM_OFF: if (req_i) begin
               state <= DOM_UP;
               cnt   <= '0;
            end
            DOM_UP: begin
               if (cnt == CW'(UP_CYC - 1)) state <= DOM_ON;
               else cnt <= cnt + 1'b1;
            end
            DOM_ON: if (!req_i) begin
               state <= DOM_DOWN;
               cnt   <= '0;
            end
            default: begin
               if (cnt == CW'(DOWN_CYC - 1)) state <= DOM_OFF;
               else cnt <= cnt + 1'b1;
            end
         endcase
      end
   end

   assign en_o  = (state == DOM_UP) || (state == DOM_ON);
   assign ack_o = (state == DOM_ON) || (state == DOM_DOWN);

   // R2: acknowledge rises only once the domain has been powered
   assert_ack_after_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(en_o));
   // R5: acknowledge falls only after the domain has been switched off
   assert_ack_after_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_o) |-> (!en_o && $past(!en_o)));
   // R6: power-up is never abandoned midway
   assert_up_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_o) |-> $past(ack_o));
endmodule

// File: rtl/dbgpwr_rst.sv
module dbgpwr_rst
   import dbgpwr_pkg::*;
#(
   parameter bit RST_EN   = 1'b1,
   parameter int HOLD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic ack_o,
   output logic dap_rst_n_o,
   output logic apb_rst_n_o,
   output logic trc_rst_n_o
);
   localparam int CW = $clog2(HOLD_CYC + 1);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("dbgpwr_rst: HOLD_CYC must be at least 1");
   end

   if (RST_EN) begin : g_impl
      rst_state_e state;
      logic [CW-1:0] cnt;
      logic assert_rst;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            state <= RST_IDLE;
            cnt   <= '0;
         end else begin
            case (state)
               RST_IDLE: if (req_i) begin
                  state <= RST_HOLD;
                  cnt   <= '0;
               end
               RST_HOLD: begin
                  if (cnt == CW'(HOLD_CYC - 1)) state <= RST_ACKD;
                  else cnt <= cnt + 1'b1;
               end
               default: if (!req_i) state <= RST_IDLE;
            endcase
         end
      end

      assign assert_rst  = (state != RST_IDLE);
      assign ack_o       = (state == RST_ACKD);
      assign dap_rst_n_o = !assert_rst;
      assign apb_rst_n_o = !assert_rst;
      assign trc_rst_n_o = !assert_rst;

      // R7: acknowledge is only given while every reset is applied
      assert_ack_in_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ack_o |-> (!dap_rst_n_o && !apb_rst_n_o && !trc_rst_n_o));
      // R7: acknowledge rises only after the resets were already held
      assert_hold_before_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ack_o) |-> $past(!dap_rst_n_o));
      // R8: resets release only once the acknowledge is gone
      assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(dap_rst_n_o) |-> !ack_o);
   end else begin : g_absent
      assign ack_o       = 1'b0;
      assign dap_rst_n_o = 1'b1;
      assign apb_rst_n_o = 1'b1;
      assign trc_rst_n_o = 1'b1;
   end
endmodule

// File: rtl/dbgpwr_ctl.sv
module dbgpwr_ctl #(
   parameter int SYNC_STAGES  = 2,
   parameter int DBG_UP_CYC   = 8,
   parameter int DBG_DOWN_CYC = 4,
   parameter int SYS_UP_CYC   = 16,
   parameter int SYS_DOWN_CYC = 6,
   parameter int RST_HOLD_CYC = 4,
   parameter bit RST_EN       = 1'b1,
   parameter int ACC_W        = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dbg_pwr_req,
   input  logic             sys_pwr_req,
   input  logic             dbg_rst_req,
   output logic             dbg_pwr_ack,
   output logic             sys_pwr_ack,
   output logic             dbg_rst_ack,
   output logic             dbg_dom_en,
   output logic             sys_dom_en,
   output logic             dap_bus_rst_n,
   output logic             dbg_apb_rst_n,
   output logic             trace_rst_n,
   input  logic [ACC_W-1:0] dbg_access_in,
   output logic [ACC_W-1:0] dbg_access_out
);
   localparam int NREQ = 3;

   if (ACC_W < 1) begin : g_bad_acc
      $error("dbgpwr_ctl: ACC_W must be at least 1");
   end

   logic [NREQ-1:0] req_raw, req_s;
   assign req_raw = {dbg_rst_req, sys_pwr_req, dbg_pwr_req};

   for (genvar i = 0; i < NREQ; i++) begin : g_sync
      dbgpwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d_i(req_raw[i]), .q_o(req_s[i]));
   end

   dbgpwr_domain #(.UP_CYC(DBG_UP_CYC), .DOWN_CYC(DBG_DOWN_CYC)) u_dbg_dom (
      .clk(clk), .rst_n(rst_n), .req_i(req_s[0]),
      .en_o(dbg_dom_en), .ack_o(dbg_pwr_ack));

   dbgpwr_domain #(.UP_CYC(SYS_UP_CYC), .DOWN_CYC(SYS_DOWN_CYC)) u_sys_dom (
      .clk(clk), .rst_n(rst_n), .req_i(req_s[1]),
      .en_o(sys_dom_en), .ack_o(sys_pwr_ack));

   dbgpwr_rst #(.RST_EN(RST_EN), .HOLD_CYC(RST_HOLD_CYC)) u_rst (
      .clk(clk), .rst_n(rst_n), .req_i(req_s[2]), .ack_o(dbg_rst_ack),
      .dap_rst_n_o(dap_bus_rst_n), .apb_rst_n_o(dbg_apb_rst_n),
      .trc_rst_n_o(trace_rst_n));

   assign dbg_access_out = dbg_access_in & {ACC_W{dbg_pwr_ack}};

   // R11: no access escapes while the debug domain is unacknowledged
   assert_gate_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_pwr_ack |-> (dbg_access_out == '0));
   // R9: debug reset never drops an established debug power acknowledge
   assert_pwr_ack_survives_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dbg_pwr_ack) && $past(dbg_pwr_req) && dbg_pwr_req && !dap_bus_rst_n)
         |-> dbg_pwr_ack);
endmodule

// File: tb/dbgpwr_ctl_test.sv
module dbgpwr_ctl_test;
   localparam int ACC_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dbg_pwr_req = 1'b0, sys_pwr_req = 1'b0, dbg_rst_req = 1'b0;
   logic [ACC_W-1:0] acc_in = '0;
   logic dbg_pwr_ack, sys_pwr_ack, dbg_rst_ack, dbg_dom_en, sys_dom_en;
   logic dap_rst_n, apb_rst_n, trc_rst_n;
   logic [ACC_W-1:0] acc_out;
   logic n_pwr_ack, n_sys_ack, n_rst_ack, n_dbg_en, n_sys_en;
   logic n_dap, n_apb, n_trc;
   logic [ACC_W-1:0] n_acc;

   int errors = 0, checks = 0, cyc = 0;

   always #2 clk = ~clk;   // 4-unit period: 250 MHz
   always @(posedge clk) cyc <= cyc + 1;

   dbgpwr_ctl #(.ACC_W(ACC_W)) uut (
      .clk(clk), .rst_n(rst_n), .dbg_pwr_req(dbg_pwr_req), .sys_pwr_req(sys_pwr_req),
      .dbg_rst_req(dbg_rst_req), .dbg_pwr_ack(dbg_pwr_ack), .sys_pwr_ack(sys_pwr_ack),
      .dbg_rst_ack(dbg_rst_ack), .dbg_dom_en(dbg_dom_en), .sys_dom_en(sys_dom_en),
      .dap_bus_rst_n(dap_rst_n), .dbg_apb_rst_n(apb_rst_n), .trace_rst_n(trc_rst_n),
      .dbg_access_in(acc_in), .dbg_access_out(acc_out));

   dbgpwr_ctl #(.ACC_W(ACC_W), .RST_EN(1'b0)) uut_norst (
      .clk(clk), .rst_n(rst_n), .dbg_pwr_req(dbg_pwr_req), .sys_pwr_req(sys_pwr_req),
      .dbg_rst_req(dbg_rst_req), .dbg_pwr_ack(n_pwr_ack), .sys_pwr_ack(n_sys_ack),
      .dbg_rst_ack(n_rst_ack), .dbg_dom_en(n_dbg_en), .sys_dom_en(n_sys_en),
      .dap_bus_rst_n(n_dap), .dbg_apb_rst_n(n_apb), .trace_rst_n(n_trc),
      .dbg_access_in(acc_in), .dbg_access_out(n_acc));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic sig(input int sel);
      case (sel)
         0: return dbg_dom_en;
         1: return dbg_pwr_ack;
         2: return sys_dom_en;
         3: return sys_pwr_ack;
         4: return dap_rst_n;
         default: return dbg_rst_ack;
      endcase
   endfunction

   // cycles from start until signal sel takes value v (sampled at negedge)
   task automatic wait_for(input int sel, input logic v, input int start, output int n);
      while (sig(sel) !== v && cyc - start < 300) @(negedge clk);
      n = cyc - start;
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 dbg_pwr_ack", dbg_pwr_ack, 0);
      check("R1 sys_pwr_ack", sys_pwr_ack, 0);
      check("R1 dbg_rst_ack", dbg_rst_ack, 0);
      check("R1 enables", {dbg_dom_en, sys_dom_en}, 0);
      check("R1 resets", {dap_rst_n, apb_rst_n, trc_rst_n}, 3'b111);
   endtask

   task automatic t_dbg_up();
      int s, n;
      acc_in = 4'b1011;
      dbg_pwr_req = 1'b1; s = cyc;
      wait_for(0, 1'b1, s, n);
      check("R2 enable latency", n, 3);
      check("R11 blocked before ack", acc_out, 0);
      wait_for(1, 1'b1, s, n);
      check("R2 ack latency", n, 11);
      check("R2 enable high at ack", dbg_dom_en, 1);
      check("R4 sys untouched", {sys_dom_en, sys_pwr_ack}, 0);
      check("R11 passed after ack", acc_out, 4'b1011);
      acc_in = 4'b0110; #0;
      check("R11 follows input", acc_out, 4'b0110);
   endtask

   task automatic t_sys_up_down();
      int s, n;
      sys_pwr_req = 1'b1; s = cyc;
      wait_for(2, 1'b1, s, n);
      check("R3 enable latency", n, 3);
      wait_for(3, 1'b1, s, n);
      check("R3 ack latency", n, 19);
      check("R4 dbg kept", {dbg_dom_en, dbg_pwr_ack}, 2'b11);
      sys_pwr_req = 1'b0; s = cyc;
      wait_for(2, 1'b0, s, n);
      check("R5 sys enable fall", n, 3);
      check("R5 sys ack still high", sys_pwr_ack, 1);
      wait_for(3, 1'b0, s, n);
      check("R5 sys ack fall", n, 9);
      check("R4 dbg kept after sys off", dbg_pwr_ack, 1);
   endtask

   task automatic t_rst();
      int s, n;
      dbg_rst_req = 1'b1; s = cyc;
      wait_for(4, 1'b0, s, n);
      check("R7 reset latency", n, 3);
      check("R7 apb/trace reset", {apb_rst_n, trc_rst_n}, 0);
      check("R7 no early ack", dbg_rst_ack, 0);
      wait_for(5, 1'b1, s, n);
      check("R7 ack latency", n, 7);
      check("R7 resets still low", {dap_rst_n, apb_rst_n, trc_rst_n}, 0);
      check("R9 pwr ack kept", dbg_pwr_ack, 1);
      check("R10 absent ack low", n_rst_ack, 0);
      check("R10 absent resets high", {n_dap, n_apb, n_trc}, 3'b111);
      idle(20);
      check("R10 absent ack still low", n_rst_ack, 0);
      check("R9 pwr ack kept long", dbg_pwr_ack, 1);
      dbg_rst_req = 1'b0; s = cyc;
      wait_for(5, 1'b0, s, n);
      check("R8 ack fall latency", n, 3);
      check("R8 resets released", {dap_rst_n, apb_rst_n, trc_rst_n}, 3'b111);
   endtask

   task automatic t_dbg_down();
      int s, n;
      dbg_pwr_req = 1'b0; s = cyc;
      wait_for(0, 1'b0, s, n);
      check("R5 dbg enable fall", n, 3);
      check("R5 dbg ack still high", dbg_pwr_ack, 1);
      wait_for(1, 1'b0, s, n);
      check("R5 dbg ack fall", n, 7);
      check("R11 blocked after off", acc_out, 0);
   endtask

   task automatic t_withdraw();
      int s, n;
      dbg_pwr_req = 1'b1; s = cyc;
      idle(2);
      dbg_pwr_req = 1'b0;
      wait_for(1, 1'b1, s, n);
      check("R6 ack still rises", n, 11);
      wait_for(1, 1'b0, s, n);
      check("R6 ack returns low", n, 16);
      check("R6 enable low", dbg_dom_en, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_dbg_up();
      t_sys_up_down();
      t_rst();
      t_dbg_down();
      idle(4);
      t_withdraw();
      idle(4);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule